// File: doc/BRIEF.md
# Board Interrupt Level Encoder

This block gathers thirteen level-sensitive interrupt lines from the peripherals on a board: four PCI INTx lines, a CompactFlash disk interface and its card-detect line, a display controller, a keypad, an RTC alarm line and an RTC tick line, an SD card slot, an external line and a touch panel. Each line has a fixed bit position in a 16-bit monitor vector. Software enables sources through a 16-bit mask register. The block finds the highest-priority active source and drives its level to the CPU on a 4-bit encoded bus. The encoding is the priority number XORed with 15, so a quiet bus reads 0.

A small 16-bit register window of 64 bytes sits beside the encoder. It holds the interrupt mask, a power-control register, a fixed version register and a general output port. The power and output-port registers drive pins of their own. The request interface accepts one access per cycle and never stalls: there is no ready signal and no back-pressure. A read returns its data on the following cycle with a one-cycle response strobe. A write returns no response.

Top module: `irq_level_agg`

## Requirements
- R1: The monitor vector follows the input levels and stores no edges. When an input falls, its request ends on the next clock edge.
- R2: The source on `src_i[n]` has priority number n, where 0 is the most urgent. It uses mask/monitor bit 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15 for n = 0 through 12. Bits 1, 2 and 3 belong to no source.
- R3: A source is active only when both its input and its mask bit are 1.
- R4: `irl_o` carries the smallest priority number among the active sources, XORed with 15. With no active source it is 0.
- R5: `irl_o` reflects the inputs and the mask value in force after the same rising edge that samples them. It therefore changes one clock after an input change or after a mask write.
- R6: The mask is read/write at byte offset 0x00. The power register is read/write at 0x30 and drives `pwr_o`. The output port is read/write at 0x36 and drives `gpo_o`. Each of these registers is 16 bits wide.
- R7: Offset 0x32 always reads 0x0010. Writes to it are discarded.
- R8: A read of any other offset returns 0. A write to any other offset changes no register and no output.
- R9: A read request gives `rsp_valid` high on the next cycle, with the data captured at the request. A write request gives no response.
- R10: Reset clears the mask, power and output-port registers. After reset `irl_o` is 0 and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 13 | Interrupt source levels, index = priority number |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset within the window |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data strobe, one cycle after a read |
| rsp_rdata | output | 16 | Read data |
| irl_o | output | 4 | Encoded interrupt level (priority XOR 15, 0 when idle) |
| pwr_o | output | 16 | Power register contents |
| gpo_o | output | 16 | Output port register contents |

## Verification
The assertions check on every cycle that reads get a response and writes do not, that the version offset and undecoded offsets read back their fixed values, and that a quiet input set or a cleared mask gives an idle level on the next edge. They also check that the most urgent source, once enabled, always wins. The non-monotonic bit map, the ordering between any two sources, and the fact that writes to the version and undecoded offsets leave every register intact can only be shown by the bench's scenarios. The bench compares against its cycle model every cycle and also probes each source on its own.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int NSRC   = 13;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam int LVL_W  = 4;

  localparam logic [ADDR_W-1:0] OFS_MASK = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_PWR  = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_VER  = 6'h32;
  localparam logic [ADDR_W-1:0] OFS_GPO  = 6'h36;
  localparam logic [DATA_W-1:0] VER_VAL  = 16'h0010;

  typedef enum logic [1:0] {SEL_NONE, SEL_MASK, SEL_PWR, SEL_GPO} reg_sel_e;

  // Mask/monitor bit position of the source whose priority number is idx.
  function automatic logic [3:0] src_bit(input int idx);
    case (idx)
      0:  src_bit = 4'd11;
      1:  src_bit = 4'd9;
      2:  src_bit = 4'd8;
      3:  src_bit = 4'd12;
      4:  src_bit = 4'd10;
      5:  src_bit = 4'd6;
      6:  src_bit = 4'd5;
      7:  src_bit = 4'd4;
      8:  src_bit = 4'd7;
      9:  src_bit = 4'd14;
      10: src_bit = 4'd13;
      11: src_bit = 4'd0;
      default: src_bit = 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/irqagg_monitor.sv
module irqagg_monitor
  import irqagg_pkg::*;
#(
  parameter int N_SRC = NSRC,
  parameter int DW    = DATA_W
) (
  input  logic [N_SRC-1:0] src_i,
  output logic [DW-1:0]    mon_o
);
  // Scatter each source level onto its bit of the monitor vector.
  always_comb begin
    mon_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      mon_o[src_bit(i)] = src_i[i];
    end
  end
endmodule

// File: rtl/irqagg_prio.sv
module irqagg_prio
  import irqagg_pkg::*;
#(
  parameter int N_SRC = NSRC,
  parameter int DW    = DATA_W,
  parameter int LW    = LVL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] mon_i,
  input  logic [DW-1:0] mask_i,
  output logic [LW-1:0] irl_o
);
  localparam logic [LW-1:0] IDLE_LVL = '1;

  logic [DW-1:0] active;
  logic [LW-1:0] best;

  // Walk from the least urgent level down, so the smallest number wins.
  always_comb begin
    active = mon_i & mask_i;
    best   = IDLE_LVL;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (active[src_bit(i)]) best = LW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irl_o <= '0;
    else        irl_o <= best ^ IDLE_LVL;
  end
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] mask_next,
  output logic [DW-1:0] pwr_q,
  output logic [DW-1:0] gpo_q,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  reg_sel_e      sel;
  logic          wr, rd;
  logic [DW-1:0] rd_mux;

  always_comb begin
    case (req_addr)
      OFS_MASK: sel = SEL_MASK;
      OFS_PWR:  sel = SEL_PWR;
      OFS_GPO:  sel = SEL_GPO;
      default:  sel = SEL_NONE;
    endcase
  end

  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  assign mask_next = (wr && sel == SEL_MASK) ? req_wdata : mask_q;

  always_comb begin
    case (sel)
      SEL_MASK: rd_mux = mask_q;
      SEL_PWR:  rd_mux = pwr_q;
      SEL_GPO:  rd_mux = gpo_q;
      default:  rd_mux = (req_addr == OFS_VER) ? VER_VAL : '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      pwr_q     <= '0;
      gpo_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      mask_q    <= mask_next;
      if (wr && sel == SEL_PWR) pwr_q <= req_wdata;
      if (wr && sel == SEL_GPO) gpo_q <= req_wdata;
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_level_agg.sv
module irq_level_agg
  import irqagg_pkg::*;
#(
  parameter int N_SRC = NSRC,
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int LW    = LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic [LW-1:0]    irl_o,
  output logic [DW-1:0]    pwr_o,
  output logic [DW-1:0]    gpo_o
);
  logic [DW-1:0] mon;
  logic [DW-1:0] mask_q;
  logic [DW-1:0] mask_next;

  irqagg_monitor #(.N_SRC(N_SRC), .DW(DW)) u_mon (
    .src_i (src_i),
    .mon_o (mon)
  );

  irqagg_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mask_q    (mask_q),
    .mask_next (mask_next),
    .pwr_q     (pwr_o),
    .gpo_q     (gpo_o),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  irqagg_prio #(.N_SRC(N_SRC), .DW(DW), .LW(LW)) u_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .mon_i  (mon),
    .mask_i (mask_next),
    .irl_o  (irl_o)
  );
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
  import irqagg_pkg::*;
#(
  parameter int N_SRC = NSRC,
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int LW    = LVL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_i,
  input logic             req_valid,
  input logic             req_write,
  input logic [AW-1:0]    req_addr,
  input logic [DW-1:0]    req_wdata,
  input logic             rsp_valid,
  input logic [DW-1:0]    rsp_rdata,
  input logic [LW-1:0]    irl_o,
  input logic [DW-1:0]    mask_q
);
  logic rd, wr_mask, undecoded;
  assign rd        = req_valid && !req_write;
  assign wr_mask   = req_valid && req_write && req_addr == OFS_MASK;
  assign undecoded = req_addr != OFS_MASK && req_addr != OFS_PWR &&
                     req_addr != OFS_VER && req_addr != OFS_GPO;

  a_r9_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  a_r9_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
  a_r7_version: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && req_addr == OFS_VER) |=> rsp_rdata == VER_VAL);
  a_r8_undecoded_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && undecoded) |=> rsp_rdata == '0);
  a_r1_quiet_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == '0) |=> irl_o == '0);
  a_r3_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && req_wdata == '0) |=> irl_o == '0);
  a_r4_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i[0] && mask_q[src_bit(0)] && !wr_mask) |=> irl_o == '1);
endmodule

bind irq_level_agg irqagg_chk #(.N_SRC(N_SRC), .DW(DW), .AW(AW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_i     (src_i),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .irl_o     (irl_o),
  .mask_q    (mask_q)
);

// File: tb/test_irq_level_agg.sv
`timescale 1ns/1ps
module test_irq_level_agg;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [12:0] src_i = '0;
  logic        req_valid = 0, req_write = 0;
  logic [5:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [3:0]  irl_o;
  logic [15:0] pwr_o, gpo_o;

  int checks = 0, failures = 0, cycles = 0;
  bit run = 0, done = 0;
  string cur_req = "R10";

  // Bit positions by priority number, from R2.
  int bitmap[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};

  // Reference model state
  logic [15:0] m_mask, m_pwr, m_gpo, m_rdata;
  logic        m_rsp;
  logic [3:0]  m_irl;

  always #2.5 clk = ~clk;

  irq_level_agg i_irq_level_agg (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irl_o(irl_o),
    .pwr_o(pwr_o), .gpo_o(gpo_o));

  function automatic int encode(logic [12:0] s, logic [15:0] m);
    for (int l = 0; l < 13; l++)
      if (s[l] && m[bitmap[l]]) return l ^ 15;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask <= 0; m_pwr <= 0; m_gpo <= 0; m_rsp <= 0; m_rdata <= 0; m_irl <= 0;
    end else begin
      logic [15:0] nm;
      nm = m_mask;
      if (req_valid && req_write) begin
        case (req_addr)
          6'h00: nm = req_wdata;
          6'h30: m_pwr <= req_wdata;
          6'h36: m_gpo <= req_wdata;
          default: ;
        endcase
      end
      m_mask <= nm;
      m_irl  <= 4'(encode(src_i, nm));
      m_rsp  <= req_valid && !req_write;
      if (req_valid && !req_write) begin
        case (req_addr)
          6'h00: m_rdata <= m_mask;
          6'h30: m_rdata <= m_pwr;
          6'h32: m_rdata <= 16'h0010;
          6'h36: m_rdata <= m_gpo;
          default: m_rdata <= 0;
        endcase
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run && rst_n) begin
      check(irl_o == m_irl, cur_req, "irl model", irl_o, m_irl);
      check(rsp_valid == m_rsp, cur_req, "rsp_valid model", rsp_valid, m_rsp);
      if (m_rsp) check(rsp_rdata == m_rdata, cur_req, "rdata model", rsp_rdata, m_rdata);
      check(pwr_o == m_pwr, cur_req, "pwr model", pwr_o, m_pwr);
      check(gpo_o == m_gpo, cur_req, "gpo model", gpo_o, m_gpo);
    end
  end

  task automatic wr(logic [5:0] a, logic [15:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    check(rsp_valid == 0, "R9", "no response to write", rsp_valid, 0);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [5:0] a, logic [15:0] exp, string req);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid == 1, "R9", "read strobe", rsp_valid, 1);
    check(rsp_rdata == exp, req, "read data", rsp_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R10";
    check(irl_o == 0, "R10", "irl in reset", irl_o, 0);
    check(pwr_o == 0 && gpo_o == 0, "R10", "regs in reset", pwr_o | gpo_o, 0);
    check(rsp_valid == 0, "R10", "rsp in reset", rsp_valid, 0);
    rst_n = 1; run = 1;
    @(negedge clk);
    rd(6'h00, 16'h0000, "R10");

    // R3: all inputs high with mask cleared
    cur_req = "R3";
    src_i = '1;
    @(negedge clk);
    check(irl_o == 0, "R3", "masked sources", irl_o, 0);

    // R4: everything enabled, most urgent wins
    cur_req = "R4";
    wr(6'h00, 16'hFFFF);
    check(irl_o == 4'hF, "R4", "level 0 wins", irl_o, 15);
    src_i[0] = 0;
    @(negedge clk);
    check(irl_o == 4'hE, "R1", "next level after drop", irl_o, 14);
    src_i = 13'b0_0010_0000_0000 | 13'b1_0000_0000_0000; // levels 9 and 12
    @(negedge clk);
    check(irl_o == 4'd6, "R4", "level 9 over 12", irl_o, 6);

    // R2/R3: each source alone, matched mask then complement
    for (int i = 0; i < 13; i++) begin
      cur_req = "R2";
      src_i = 13'(1 << i);
      wr(6'h00, 16'(1 << bitmap[i]));
      check(irl_o == 4'(i ^ 15), "R2", "single source map", irl_o, i ^ 15);
      cur_req = "R3";
      wr(6'h00, ~16'(1 << bitmap[i]));
      check(irl_o == 0, "R3", "own bit masked", irl_o, 0);
    end

    // R5/R1: one-clock response to input edges
    cur_req = "R5";
    wr(6'h00, 16'hFFFF);
    src_i = '0;
    @(negedge clk);
    src_i[5] = 1;
    @(negedge clk);
    check(irl_o == 4'd10, "R5", "rise seen after one edge", irl_o, 10);
    src_i[5] = 0;
    @(negedge clk);
    check(irl_o == 0, "R1", "level not latched", irl_o, 0);
    src_i[8] = 1;
    @(negedge clk);
    wr(6'h00, 16'h0000);
    check(irl_o == 0, "R5", "mask write effective same edge", irl_o, 0);

    // R6: read/write registers
    cur_req = "R6";
    wr(6'h30, 16'hA5A5);
    wr(6'h36, 16'h1234);
    wr(6'h00, 16'h0F0E);
    rd(6'h30, 16'hA5A5, "R6");
    rd(6'h36, 16'h1234, "R6");
    rd(6'h00, 16'h0F0E, "R6");
    check(pwr_o == 16'hA5A5 && gpo_o == 16'h1234, "R6", "pins", pwr_o, 16'hA5A5);

    // R7: version
    cur_req = "R7";
    wr(6'h32, 16'hFFFF);
    rd(6'h32, 16'h0010, "R7");

    // R8: undecoded offsets
    cur_req = "R8";
    wr(6'h02, 16'hDEAD);
    wr(6'h34, 16'hBEEF);
    wr(6'h3E, 16'h5555);
    wr(6'h31, 16'h7777);
    rd(6'h02, 16'h0000, "R8");
    rd(6'h3E, 16'h0000, "R8");
    rd(6'h00, 16'h0F0E, "R8");
    rd(6'h30, 16'hA5A5, "R8");
    rd(6'h36, 16'h1234, "R8");

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule